// File: doc/BRIEF.md
# Round-Robin Packet Stream Multiplexer

This block merges several 32-bit packet streams, each with valid, ready and end-of-packet, into one outgoing stream toward an Ethernet MAC that takes valid, ready and last. A source is granted for the whole of a packet. The grant moves only once the final beat of that packet has been taken. The next source is the first requester found when scanning in circular order, starting just past the channel that was granted last.

All outputs come from registers. A one-beat holding slot sits behind the output register. When the MAC stalls, this slot absorbs the beat that was already in flight, because the ready toward the source is itself registered and can only react one cycle late. When the MAC releases, the slot drains first. Full throughput is kept with no combinational path from the MAC's ready back to the sources.

The block is built for eight or four inputs. Two instances can be cascaded, eight-to-one feeding four-to-one, to merge more streams. Each stage adds one cycle of latency.

Top module: `pkt_rr_mux`

## Requirements
- R1: The parameter N_CH takes the value 8 or 4. Input channel i uses bit i of the valid, last and ready vectors and bits [i*32+31:i*32] of the flat data vector.
- R2: While rst_ni is low and on the first cycle after it rises, mac_valid_o and every bit of src_ready_o are 0. The remembered channel starts at 0, so the first scan begins at channel 1.
- R3: When no packet is in progress, the next grant goes to the first channel with valid high, scanning current+1, current+2, and so on, wrapping modulo N_CH. The current channel itself is scanned last. With current channel 7, channel 0 wins over channel 1.
- R4: At most one bit of src_ready_o is 1, and only for the granted channel. No other channel is accepted until the granted channel's beat with last=1 has been accepted.
- R5: A beat accepted at a clock edge appears on mac_valid_o, mac_data_o and mac_last_o after that same edge. From idle, a request first shows on mac_valid_o two edges after valid rises: one edge to grant, one to register.
- R6: While mac_valid_o=1 and mac_ready_i=0, mac_valid_o, mac_data_o and mac_last_o keep their values on the next cycle.
- R7: If a beat is accepted while the output is stalled, src_ready_o is all zero on the next cycle. At most one beat is held, and no beat is lost or duplicated under any back-pressure pattern.
- R8: After a stall ends, the held beat is sent next. With mac_ready_i held at 1, a packet of L beats leaves in L consecutive cycles.
- R9: When no channel requests after a packet, mac_valid_o returns to 0 once the last beat is taken. The remembered channel is kept as the start point of the next scan.
- R10: A gap in the granted channel's valid in the middle of a packet does not let another requesting channel in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_valid_i | input | N_CH | Per-channel beat valid |
| src_data_i | input | N_CH*DATA_W | Per-channel beat data, channel i at [i*DATA_W +: DATA_W] |
| src_last_i | input | N_CH | Per-channel end-of-packet flag |
| src_ready_o | output | N_CH | Per-channel ready, at most one bit set |
| mac_valid_o | output | 1 | Output beat valid |
| mac_data_o | output | DATA_W | Output beat data |
| mac_last_o | output | 1 | Output end-of-packet flag |
| mac_ready_i | input | 1 | Downstream ready |

## Verification
Several properties are checked on every cycle:
- ready toward the sources is one-hot or zero, and the grant stays on one channel until the last beat of its packet is accepted;
- outputs stay frozen while stalled;
- ready drops after a beat is accepted into a stalled output;
- output valid rises only after an accepted beat.

Other behaviours can only be shown by the bench scenarios:
- the circular grant order, including wrap-around from channel 7 to 0 and the reset start point;
- beat-exact ordering with no loss or duplication under alternating, pseudo-random and long back-pressure;
- the two-edge latency from idle and back-to-back throughput.

Every output beat is compared against a stream the bench rebuilds from the channel's packet counts and the round-robin rule.

// File: rtl/pkt_rr_mux_pkg.sv
package pkt_rr_mux_pkg;

  typedef enum logic {
    ARB_SCAN = 1'b0,
    ARB_PKT  = 1'b1
  } arb_state_e;

  function automatic int unsigned sel_width(int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/pkt_rr_pick.sv
module pkt_rr_pick #(
  parameter int unsigned N_CH  = 8,
  parameter int unsigned SEL_W = 3
) (
  input  logic [N_CH-1:0]  req_i,
  input  logic [SEL_W-1:0] cur_i,
  output logic             found_o,
  output logic [SEL_W-1:0] pick_o
);

  // scan from farthest to nearest so the nearest requester after cur_i wins
  always_comb begin
    int idx;
    found_o = 1'b0;
    pick_o  = cur_i;
    for (int k = N_CH; k >= 1; k--) begin
      idx = (int'(cur_i) + k) % int'(N_CH);
      if (req_i[idx]) begin
        found_o = 1'b1;
        pick_o  = SEL_W'(idx);
      end
    end
  end

endmodule

// File: rtl/pkt_beat_slot.sv
module pkt_beat_slot #(
  parameter int unsigned W = 33
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_beat_i,
  output logic         in_ready_o,
  output logic         out_valid_o,
  output logic [W-1:0] out_beat_o,
  input  logic         out_ready_i
);

  logic         out_v_q, hold_v_q;
  logic [W-1:0] out_b_q, hold_b_q;
  logic         accept, advance;

  assign in_ready_o  = ~hold_v_q;
  assign accept      = in_valid_i & ~hold_v_q;
  assign advance     = ~out_v_q | out_ready_i;
  assign out_valid_o = out_v_q;
  assign out_beat_o  = out_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_v_q  <= 1'b0;
      out_b_q  <= '0;
      hold_v_q <= 1'b0;
      hold_b_q <= '0;
    end else begin
      // holding slot captures every accepted beat; only marked full on stall
      if (accept) hold_b_q <= in_beat_i;
      if (advance) begin
        if (hold_v_q) begin
          out_v_q  <= 1'b1;
          out_b_q  <= hold_b_q;
          hold_v_q <= 1'b0;
        end else begin
          out_v_q <= accept;
          if (accept) out_b_q <= in_beat_i;
        end
      end else if (accept) begin
        hold_v_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pkt_rr_mux.sv
module pkt_rr_mux #(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_CH-1:0]        src_valid_i,
  input  logic [N_CH*DATA_W-1:0] src_data_i,
  input  logic [N_CH-1:0]        src_last_i,
  output logic [N_CH-1:0]        src_ready_o,
  output logic                   mac_valid_o,
  output logic [DATA_W-1:0]      mac_data_o,
  output logic                   mac_last_o,
  input  logic                   mac_ready_i
);
  import pkt_rr_mux_pkg::*;

  localparam int unsigned SEL_W  = sel_width(N_CH);
  localparam int unsigned BEAT_W = DATA_W + 1;

  initial begin
    assert (N_CH == 4 || N_CH == 8) else $error("pkt_rr_mux: N_CH must be 4 or 8");
  end

  arb_state_e       state_q;
  logic [SEL_W-1:0] sel_q;
  logic             found;
  logic [SEL_W-1:0] pick;

  logic [DATA_W-1:0] lane [N_CH];
  logic              in_valid, slot_ready, accept, in_last;
  logic [BEAT_W-1:0] in_beat, out_beat;

  for (genvar g = 0; g < N_CH; g++) begin : g_lane
    assign lane[g]        = src_data_i[g*DATA_W +: DATA_W];
    assign src_ready_o[g] = (state_q == ARB_PKT) && slot_ready && (sel_q == SEL_W'(g));
  end

  pkt_rr_pick #(.N_CH(N_CH), .SEL_W(SEL_W)) u_pick (
    .req_i  (src_valid_i),
    .cur_i  (sel_q),
    .found_o(found),
    .pick_o (pick)
  );

  assign in_last  = src_last_i[sel_q];
  assign in_valid = (state_q == ARB_PKT) && src_valid_i[sel_q];
  assign in_beat  = {in_last, lane[sel_q]};
  assign accept   = in_valid && slot_ready;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ARB_SCAN;
      sel_q   <= '0;
    end else begin
      case (state_q)
        ARB_SCAN: if (found) begin
          sel_q   <= pick;
          state_q <= ARB_PKT;
        end
        ARB_PKT: if (accept && in_last) state_q <= ARB_SCAN;
        default: state_q <= ARB_SCAN;
      endcase
    end
  end

  pkt_beat_slot #(.W(BEAT_W)) u_slot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid),
    .in_beat_i  (in_beat),
    .in_ready_o (slot_ready),
    .out_valid_o(mac_valid_o),
    .out_beat_o (out_beat),
    .out_ready_i(mac_ready_i)
  );

  assign mac_data_o = out_beat[DATA_W-1:0];
  assign mac_last_o = out_beat[DATA_W];

endmodule

// File: rtl/pkt_rr_mux_chk.sv
module pkt_rr_mux_chk #(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [N_CH-1:0]        src_valid_i,
  input logic [N_CH-1:0]        src_last_i,
  input logic [N_CH-1:0]        src_ready_o,
  input logic                   mac_valid_o,
  input logic [DATA_W-1:0]      mac_data_o,
  input logic                   mac_last_o,
  input logic                   mac_ready_i
);

  logic fire, fire_last;
  assign fire      = |(src_valid_i & src_ready_o);
  assign fire_last = |(src_valid_i & src_ready_o & src_last_i);

  p_ready_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(src_ready_o));

  p_grant_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !fire_last) |=> (src_ready_o == '0 || src_ready_o == $past(src_ready_o)));

  p_out_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mac_valid_o && !mac_ready_i) |=> (mac_valid_o && $stable(mac_data_o) && $stable(mac_last_o)));

  p_ready_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mac_valid_o && !mac_ready_i && fire) |=> (src_ready_o == '0));

  p_valid_source_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mac_valid_o) |-> $past(fire));

endmodule

bind pkt_rr_mux pkt_rr_mux_chk #(.N_CH(N_CH), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_valid_i(src_valid_i),
  .src_last_i (src_last_i),
  .src_ready_o(src_ready_o),
  .mac_valid_o(mac_valid_o),
  .mac_data_o (mac_data_o),
  .mac_last_o (mac_last_o),
  .mac_ready_i(mac_ready_i)
);

// File: tb/tb_pkt_rr_mux.sv
`timescale 1ns/1ps
module tb_pkt_rr_mux;
  localparam int N = 8;
  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   src_valid = '0;
  logic [N*W-1:0] src_data = '0;
  logic [N-1:0]   src_last = '0;
  logic [N-1:0]   src_ready;
  logic           mac_valid;
  logic [W-1:0]   mac_data;
  logic           mac_last;
  logic           mac_ready = 1'b1;

  always #2.5 clk = ~clk;

  pkt_rr_mux #(.N_CH(N), .DATA_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .src_valid_i(src_valid), .src_data_i(src_data), .src_last_i(src_last),
    .src_ready_o(src_ready),
    .mac_valid_o(mac_valid), .mac_data_o(mac_data), .mac_last_o(mac_last),
    .mac_ready_i(mac_ready)
  );

  int checks = 0, fails = 0;
  int src_rem[N], src_pkt[N], src_beat[N];
  int out_rem[N], out_pkt[N], stage[N];
  int exp_last_ch = 0, exp_ch = -1, exp_beat = 0;
  int bp_mode = 0, gap_mode = 0, fix_len = 0;
  int cyc = 0, scn_beats = 0, first_cyc = -1, last_cyc = -1, start_cyc = 0;
  bit prev_stall = 0;
  logic [W-1:0] prev_data;
  logic prev_last;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  function automatic int plen(int ch, int p);
    if (fix_len > 0) return fix_len;
    return 1 + ((ch * 3 + p * 5) % 4);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // source drivers, back-pressure and scoreboard
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      for (int ch = 0; ch < N; ch++) begin
        if (src_rem[ch] > 0 && !(gap_mode != 0 && src_beat[ch] > 0 && (cyc % 3) == 0)) begin
          src_valid[ch] = 1'b1;
          src_data[ch*W +: W] = {8'(ch), 8'(src_pkt[ch]), 16'(src_beat[ch])};
          src_last[ch] = (src_beat[ch] == plen(ch, src_pkt[ch]) - 1);
        end else begin
          src_valid[ch] = 1'b0;
          src_data[ch*W +: W] = '0;
          src_last[ch] = 1'b0;
        end
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (bp_mode)
        1: mac_ready = cyc[0];
        2: mac_ready = lfsr[0];
        3: mac_ready = ((cyc % 8) >= 6);
        default: mac_ready = 1'b1;
      endcase
      #1;
      if (rst_n) check($countones(src_ready) <= 1, "R4", "ready not one-hot", src_ready, 0);
      for (int ch = 0; ch < N; ch++) begin
        if (src_valid[ch] && src_ready[ch]) begin
          if (src_last[ch]) begin
            src_rem[ch]--; src_pkt[ch]++; src_beat[ch] = 0;
          end else src_beat[ch]++;
        end
      end
      if (prev_stall) begin
        check(mac_valid == 1'b1, "R6", "valid dropped in stall", mac_valid, 1);
        check(mac_data == prev_data, "R6", "data moved in stall", mac_data, prev_data);
        check(mac_last == prev_last, "R6", "last moved in stall", mac_last, prev_last);
      end
      prev_stall = mac_valid && !mac_ready;
      prev_data  = mac_data;
      prev_last  = mac_last;
      if (mac_valid && mac_ready) begin
        if (exp_beat == 0) begin
          exp_ch = -1;
          for (int k = 1; k <= N; k++) begin
            int c;
            c = (exp_last_ch + k) % N;
            if (exp_ch < 0 && out_rem[c] > 0) exp_ch = c;
          end
        end
        if (exp_ch < 0) check(0, "R7", "unexpected beat", mac_data, 0);
        else begin
          logic [W-1:0] expd;
          logic expl;
          expd = {8'(exp_ch), 8'(out_pkt[exp_ch]), 16'(exp_beat)};
          expl = (exp_beat == plen(exp_ch, out_pkt[exp_ch]) - 1);
          check(mac_data == expd, "R3", "beat order/content", mac_data, expd);
          check(mac_last == expl, "R4", "last flag", mac_last, expl);
          if (expl) begin
            out_rem[exp_ch]--; out_pkt[exp_ch]++; exp_last_ch = exp_ch; exp_beat = 0;
          end else exp_beat++;
        end
        if (first_cyc < 0) first_cyc = cyc;
        last_cyc = cyc;
        scn_beats++;
      end
    end
  end

  task automatic go(int bp, int gap, int fl);
    int guard;
    bit busy;
    @(posedge clk);
    bp_mode = bp; gap_mode = gap; fix_len = fl;
    scn_beats = 0; first_cyc = -1; last_cyc = -1; start_cyc = cyc;
    for (int ch = 0; ch < N; ch++) begin
      src_rem[ch] = stage[ch]; out_rem[ch] = stage[ch]; stage[ch] = 0;
    end
    guard = 0;
    do begin
      @(negedge clk); #2;
      busy = 0;
      for (int ch = 0; ch < N; ch++) if (out_rem[ch] > 0 || src_rem[ch] > 0) busy = 1;
      guard++;
    end while (busy && guard < 20000);
    check(!busy, "R7", "watchdog: packets missing", guard, 0);
    repeat (3) @(negedge clk);
    #2;
    check(mac_valid == 1'b0, "R9", "valid after idle", mac_valid, 0);
    bp_mode = 0;
  endtask

  initial begin
    for (int ch = 0; ch < N; ch++) begin
      src_rem[ch] = 0; src_pkt[ch] = 0; src_beat[ch] = 0;
      out_rem[ch] = 0; out_pkt[ch] = 0; stage[ch] = 0;
    end
    repeat (3) @(negedge clk);
    #2;
    check(mac_valid == 1'b0, "R2", "valid in reset", mac_valid, 0);
    check(src_ready == '0, "R2", "ready in reset", src_ready, 0);
    rst_n = 1'b1;
    @(negedge clk); #2;
    check(mac_valid == 1'b0, "R2", "valid after reset", mac_valid, 0);
    check(src_ready == '0, "R2", "ready after reset", src_ready, 0);

    // R2/R3: start point 0 -> channel 3 before channel 0; R5 two-edge latency
    stage[0] = 1; stage[3] = 1;
    go(0, 0, 1);
    check(first_cyc - start_cyc == 3, "R5", "idle-to-valid latency", first_cyc - start_cyc, 3);
    check(scn_beats == 2, "R1", "lane beats", scn_beats, 2);
    // current now 0; move to 7, then 0 must beat 1 (R3 wrap)
    stage[7] = 1;
    go(0, 0, 2);
    stage[0] = 1; stage[1] = 1;
    go(0, 0, 1);
    check(exp_last_ch == 1, "R3", "wrap order end channel", exp_last_ch, 1);
    // R8 throughput
    stage[5] = 1;
    go(0, 0, 16);
    check(last_cyc - first_cyc == 15, "R8", "16-beat packet span", last_cyc - first_cyc, 15);
    // all channels, varied lengths, several back-pressure patterns
    for (int ch = 0; ch < N; ch++) stage[ch] = 3;
    go(0, 0, 0);
    for (int ch = 0; ch < N; ch++) stage[ch] = 3;
    go(1, 0, 0);
    for (int ch = 0; ch < N; ch++) stage[ch] = 4;
    go(2, 1, 0);
    // R10 gaps with competing channels
    stage[2] = 4; stage[6] = 4;
    go(2, 1, 0);
    for (int ch = 0; ch < N; ch++) stage[ch] = 2;
    go(3, 1, 0);
    stage[4] = 1;
    go(3, 0, 5);
    check(scn_beats == 5, "R7", "beats under long stall", scn_beats, 5);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #900000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R7 global watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule